// File: doc/BRIEF.md
# Three-Input Gated Latching Multiplexer

This block is a data-path word merger with its own storage. Three data words arrive together, and each has its own gate strobe. The output is the bitwise OR of every word whose strobe is active, plus the content of an internal storage register. There is no encoded select. Turning on several strobes at once is legal, and their words combine bit by bit.

A single latch control drives the storage register. At every clock edge where the latch control is low, the register is cleared, so the output shows only the gated words. At the first edge where the latch control is high after being low, the register takes the output word present in that cycle. It then keeps that word for as long as the latch control stays high, whatever the strobes do afterwards. The datapath is a row of identical one-bit slices. A parameter selects whether the row is built slice by slice or as one vector expression.

Top module: `lmux_latching`

## Requirements
- R1: The word width is the parameter WIDTH (default 16), and every bit position behaves identically.
- R2: When the storage is clear and exactly one strobe is active, the output equals that strobe's data word.
- R3: When several strobes are active, the output is the bitwise OR of their data words. A word whose strobe is low contributes nothing.
- R4: When the storage is clear and no strobe is active, the output is all zeros.
- R5: A clock edge with the latch control low clears the storage. From the next cycle onward, the output again reflects only the gated words.
- R6: A clock edge where the latch control is high and was low at the previous edge captures the output word of the cycle before that edge into the storage.
- R7: While the latch control stays high, the stored word is kept. With all strobes low, the output equals the captured word, even if data words change.
- R8: While a word is held, any active strobe still ORs its data word onto the output.
- R9: A synchronous active-high reset clears the storage and the latch history. If the latch control is high when reset is released, a capture happens at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| latch_en | input | 1 | Latch control: low clears storage, a low-to-high step captures |
| gate_a | input | 1 | Strobe for word A |
| gate_b | input | 1 | Strobe for word B |
| gate_c | input | 1 | Strobe for word C |
| din_a | input | WIDTH | Data word A |
| din_b | input | WIDTH | Data word B |
| din_c | input | WIDTH | Data word C |
| dout | output | WIDTH | Stored word OR-ed with all gated words |

## Verification
The gated part of the output is combinational, so a strobe or data change shows up in the same cycle. The bench drives inputs on the falling edge and samples about a nanosecond later. A clear or a capture takes effect only at the next rising edge. Each clear, capture or hold check is therefore sampled after the falling edge that follows the edge that caused it, never earlier. Sweeps cover every strobe combination against a set of arithmetically generated data words. The expected output is the OR of the gated words, plus the word the bench itself recorded at the capture edge.

// File: rtl/lmux_pkg.sv
package lmux_pkg;

   // Action applied to the storage register at a clock edge
   typedef enum logic [1:0] {
      ST_HOLD    = 2'd0,
      ST_CLEAR   = 2'd1,
      ST_CAPTURE = 2'd2
   } st_action_e;

   localparam int unsigned LMUX_MAX_WIDTH = 64;
   localparam int unsigned LMUX_NUM_SRC   = 3;

   // Decide the storage action from the present latch level and the level seen at the last edge
   function automatic st_action_e decide_action(input logic rst_i,
                                                input logic lat_now,
                                                input logic lat_prev);
      st_action_e act;
      if (rst_i)
         act = ST_CLEAR;
      else if (!lat_now)
         act = ST_CLEAR;
      else if (!lat_prev)
         act = ST_CAPTURE;
      else
         act = ST_HOLD;
      return act;
   endfunction

endpackage

// File: rtl/lmux_gate_slice.sv
module lmux_gate_slice (
   input  logic gate_a,
   input  logic gate_b,
   input  logic gate_c,
   input  logic bit_a,
   input  logic bit_b,
   input  logic bit_c,
   input  logic bit_st,
   output logic bit_o
);

   logic term_a;
   logic term_b;
   logic term_c;

   always_comb begin
      term_a = gate_a & bit_a;
      term_b = gate_b & bit_b;
      term_c = gate_c & bit_c;
      bit_o  = bit_st | term_a | term_b | term_c;
   end

endmodule

// File: rtl/lmux_store.sv
module lmux_store
   import lmux_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             latch_en,
   input  logic [WIDTH-1:0] cap_word,
   output logic [WIDTH-1:0] st_word
);

   localparam logic [WIDTH-1:0] ZERO_W = '0;

   logic       lat_seen;
   st_action_e act;

   always_comb begin
      act = decide_action(rst, latch_en, lat_seen);
   end

   always_ff @(posedge clk) begin
      if (rst)
         lat_seen <= 1'b0;
      else
         lat_seen <= latch_en;
   end

   always_ff @(posedge clk) begin
      unique case (act)
         ST_CLEAR:   st_word <= ZERO_W;
         ST_CAPTURE: st_word <= cap_word;
         default:    st_word <= st_word;
      endcase
   end

endmodule

// File: rtl/lmux_latching.sv
module lmux_latching
   import lmux_pkg::*;
#(
   parameter int unsigned WIDTH     = 16,
   parameter bit          BIT_SLICE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             latch_en,
   input  logic             gate_a,
   input  logic             gate_b,
   input  logic             gate_c,
   input  logic [WIDTH-1:0] din_a,
   input  logic [WIDTH-1:0] din_b,
   input  logic [WIDTH-1:0] din_c,
   output logic [WIDTH-1:0] dout
);

   localparam int unsigned MSB = WIDTH - 1;

   initial begin
      assert (WIDTH >= 1 && WIDTH <= LMUX_MAX_WIDTH)
         else $error("lmux_latching: WIDTH %0d outside 1..%0d", WIDTH, LMUX_MAX_WIDTH);
      assert (LMUX_NUM_SRC == 3)
         else $error("lmux_latching: source count must be three");
   end

   logic [MSB:0] st_word;
   logic [MSB:0] mux_word;

   // R6 capture path: the storage takes the full mux output
   lmux_store #(.WIDTH(WIDTH)) u_store (
      .clk      (clk),
      .rst      (rst),
      .latch_en (latch_en),
      .cap_word (mux_word),
      .st_word  (st_word)
   );

   // R1 identical per-bit slices or a single vector form
   generate
      if (BIT_SLICE) begin : g_slices
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            lmux_gate_slice u_slice (
               .gate_a (gate_a),
               .gate_b (gate_b),
               .gate_c (gate_c),
               .bit_a  (din_a[i]),
               .bit_b  (din_b[i]),
               .bit_c  (din_c[i]),
               .bit_st (st_word[i]),
               .bit_o  (mux_word[i])
            );
         end
      end else begin : g_vector
         always_comb begin
            mux_word = st_word
                     | (din_a & {WIDTH{gate_a}})
                     | (din_b & {WIDTH{gate_b}})
                     | (din_c & {WIDTH{gate_c}});
         end
      end
   endgenerate

   assign dout = mux_word;

endmodule

// File: rtl/lmux_latching_chk.sv
module lmux_latching_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             latch_en,
   input logic             gate_a,
   input logic             gate_b,
   input logic             gate_c,
   input logic [WIDTH-1:0] din_a,
   input logic [WIDTH-1:0] din_b,
   input logic [WIDTH-1:0] din_c,
   input logic [WIDTH-1:0] dout
);

   logic             l1;
   logic             l2;
   logic             r1;
   logic             g_prev;
   logic [WIDTH-1:0] pd;
   logic [WIDTH-1:0] gated_now;
   logic             g_any;

   always_comb begin
      gated_now = (gate_a ? din_a : '0) | (gate_b ? din_b : '0) | (gate_c ? din_c : '0);
      g_any     = gate_a | gate_b | gate_c;
   end

   always_ff @(posedge clk) begin
      r1 <= rst;
      if (rst) begin
         l1     <= 1'b0;
         l2     <= 1'b0;
         g_prev <= 1'b0;
         pd     <= '0;
      end else begin
         l1     <= latch_en;
         l2     <= l1;
         g_prev <= g_any;
         pd     <= dout;
      end
   end

   // R2
   clr_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !l1 |-> dout == gated_now);

   // R4
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!l1 && !g_any) |-> dout == '0);

   // R6
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      (l1 && !l2) |-> (dout & pd) == pd);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (l1 && l2 && !g_any && !g_prev) |-> dout == pd);

   // R8
   or_held_chk: assert property (@(posedge clk) disable iff (rst)
      (l1 && l2) |-> (dout & gated_now) == gated_now);

   // R9
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (r1 && !g_any) |-> dout == '0);

endmodule

bind lmux_latching lmux_latching_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .latch_en (latch_en),
   .gate_a   (gate_a),
   .gate_b   (gate_b),
   .gate_c   (gate_c),
   .din_a    (din_a),
   .din_b    (din_b),
   .din_c    (din_c),
   .dout     (dout)
);

// File: tb/lmux_latching_test.sv
`timescale 1ns/1ps
module lmux_latching_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst;
   logic         latch_en;
   logic         gate_a, gate_b, gate_c;
   logic [W-1:0] din_a, din_b, din_c;
   logic [W-1:0] dout;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   lmux_latching #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .latch_en(latch_en),
      .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
      .din_a(din_a), .din_b(din_b), .din_c(din_c),
      .dout(dout)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dout=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat(input int k, input int salt);
      return W'((k * 16'h3A71 + salt * 16'h1F5B) ^ (k << 5) ^ (salt * 16'h0C3D));
   endfunction

   function automatic logic [W-1:0] gated(input logic [2:0] g,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic [W-1:0] c);
      return (g[0] ? a : '0) | (g[1] ? b : '0) | (g[2] ? c : '0);
   endfunction

   task automatic drive(input logic [2:0] g, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] c);
      {gate_c, gate_b, gate_a} = g;
      din_a = a; din_b = b; din_c = c;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: dout=%h expected=run end", dout);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] cap;
      logic [W-1:0] a, b, c;
      rst = 1'b1; latch_en = 1'b0;
      drive(3'b000, '0, '0, '0);
      repeat (3) @(negedge clk);
      #1 check("R9 reset state", dout, '0);
      @(negedge clk);
      rst = 1'b0;

      // R2 R3 R4 R1: storage clear, every strobe combination, many words
      for (int g = 0; g < 8; g++) begin
         for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            a = pat(k, 1); b = pat(k, 2); c = pat(k, 3);
            drive(3'(g), a, b, c);
            #1;
            if (g == 0)
               check("R4 no strobe", dout, '0);
            else if (g == 1 || g == 2 || g == 4)
               check("R2 single strobe", dout, gated(3'(g), a, b, c));
            else
               check("R3 strobes OR", dout, gated(3'(g), a, b, c));
         end
      end
      // R1 walking single bit through all positions
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         drive(3'b010, '0, W'(1) << i, '1);
         #1 check("R1 bit slice", dout, W'(1) << i);
      end

      // R6 R7 R8 R5: capture, hold, overlay, clear
      for (int g = 1; g < 8; g++) begin
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            latch_en = 1'b0;
            drive(3'b000, '0, '0, '0);
            @(negedge clk);
            a = pat(k, g + 4); b = pat(k, g + 9); c = pat(k, g + 13);
            drive(3'(g), a, b, c);
            latch_en = 1'b1;
            cap = gated(3'(g), a, b, c);
            @(negedge clk);
            drive(3'b000, ~a, ~b, ~c);
            #1 check("R6 capture", dout, cap);
            @(negedge clk);
            drive(3'b000, pat(k, 40), pat(k, 41), pat(k, 42));
            #1 check("R7 hold", dout, cap);
            @(negedge clk);
            a = pat(k, 50 + g);
            drive(3'b001, a, '0, '0);
            #1 check("R8 overlay", dout, cap | a);
            @(negedge clk);
            drive(3'b000, '0, '0, '0);
            #1 check("R7 hold after overlay", dout, cap);
            latch_en = 1'b0;
            @(negedge clk);
            #1 check("R5 clear", dout, '0);
         end
      end

      // R9 latch high while reset releases: capture at first edge after reset
      @(negedge clk);
      rst = 1'b1; latch_en = 1'b1;
      a = 16'hA5C3;
      drive(3'b001, a, '0, '0);
      @(negedge clk);
      rst = 1'b0;
      #1 check("R9 reset cleared", dout, a);
      @(negedge clk);
      drive(3'b000, '0, '0, '0);
      #1 check("R9 capture after reset", dout, a);
      @(negedge clk);
      latch_en = 1'b0;
      @(negedge clk);
      #1 check("R5 clear after reset capture", dout, '0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule